// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block is the clocked front end of a flow-through synchronous SRAM, together with a small behavioural storage array. Every control input is sampled on the rising clock edge. A burst begins when either of two address strobes is active. One strobe is meant for a processor and the other for a cache controller. The block then walks the remaining words of an aligned four-word group with a two-bit beat counter. The walk uses either a linear or an interleaved order, chosen when the burst starts.

The advance input lets the counter step, and holding advance low pauses the burst on its current word. Writes are decoded per byte: one global write input covers every byte, and a byte-write enable applies a per-byte select mask. When neither is active, the cycle is a read.

Read data is flow-through. The word at the address registered by an edge appears on the read port during the clock period that follows that same edge. The output driver is gated by an asynchronous output enable. It is also switched off after write cycles, deselect cycles and sleep. A sleep input stops the array from being written and leaves the device deselected.

Top module: `sbsram_ctrl`

## Requirements
- R1: On a rising edge where `strobe_cpu` or `strobe_ctl` is high, the block registers `addr`. It also registers the select state, which is selected only when both `chip_sel_a` and `chip_sel_b` are high. That registered word is the current address for the period after the edge.
- R2: During a burst, only the two lowest address bits change. The upper address bits keep the value registered at the strobe.
- R3: If `order_ilv` is high at the strobe edge, the low two bits after beat k are the starting low bits XOR k.
- R4: If `order_ilv` is low at the strobe edge, the low two bits after beat k are the starting low bits plus k, modulo 4.
- R5: On an edge with no strobe and `advance` low, the current address is unchanged.
- R6: After four advances, the burst returns to its starting address rather than moving on to the next group of four.
- R7: On a write cycle, `wr_all` high writes all four bytes of `wdata` to the new current address.
- R8: With `wr_all` low and `wr_bytes_en` high, only the bytes whose `wr_byte_sel` bit is set are written. Bit i covers `wdata` bits 8i+7..8i. With both low, nothing is written.
- R9: After a read edge, `rdata_oe` is high and `rdata` holds the stored word at the current address within the same clock period, provided `out_en` is high and the device is selected.
- R10: While `out_en` is low, `rdata_oe` is low and `rdata` reads zero, independent of the clock.
- R11: The device is deselected after reset, and also after a strobe edge where either chip select is low. While deselected, `rdata_oe` stays low and write inputs store nothing until the next strobe.
- R12: An edge with `sleep` high writes nothing and deselects the device. `rdata_oe` is low while `sleep` is high, and it stays low after `sleep` falls until a new strobe selects the device.
- R13: A strobe edge where `strobe_cpu` is high is a read: the write inputs are ignored on that edge, even if `strobe_ctl` is also high. On later edges of the same burst, the write inputs act as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_cpu | input | 1 | Processor address strobe; starts a burst and ignores write inputs on that edge |
| strobe_ctl | input | 1 | Controller address strobe; starts a burst and may write on that edge |
| chip_sel_a | input | 1 | First chip select, sampled with a strobe |
| chip_sel_b | input | 1 | Second chip select, sampled with a strobe |
| addr | input | ADDR_W | Word address captured at a strobe |
| advance | input | 1 | Steps the burst counter when high |
| order_ilv | input | 1 | Burst order captured at a strobe: 1 interleaved, 0 linear |
| wr_all | input | 1 | Global write of all bytes |
| wr_bytes_en | input | 1 | Byte-write enable qualifying wr_byte_sel |
| wr_byte_sel | input | NB | Per-byte write select |
| wdata | input | NB*BYTE_W | Write data |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Sleep request; blocks writes and deselects |
| rdata | output | NB*BYTE_W | Read data, zero while not driven |
| rdata_oe | output | 1 | High while the read data bus is driven |

## Verification
The assertions check the cycle-level rules on every clock. These include capture at a strobe, fixed upper bits, the one-step relation between successive addresses in each order, holding while advance is low, and the output being disabled under output enable, deselect and sleep. They also cover the write-mask rules for global write, read cycles, processor strobes and sleep.

The data path is shown only by the bench scenarios, which compare every beat against a byte-masked reference memory. That covers the order in which stored words come back, the wrap after four beats, partial byte writes landing in the right lanes, and the absence of any write during deselect, sleep or processor-strobe edges.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;
   // Burst walk order, captured once per burst at the strobe edge.
   typedef enum logic {
      ORD_LIN = 1'b0,
      ORD_ILV = 1'b1
   } order_e;
endpackage

// File: rtl/sbsram_burst_seq.sv
`timescale 1ns/1ps
// Address register and beat counter. Produces both the registered current
// address (read side) and the address that the coming edge will register
// (write side).
module sbsram_burst_seq
   import sbsram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              strobe,
   input  logic              sel_in,
   input  logic              order_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              advance,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic              active,
   output logic              nxt_active
);
   localparam int HI_W = ADDR_W - CNT_W;

   generate
      if (CNT_W < 1 || HI_W < 1) begin : g_bad_widths
         $error("sbsram_burst_seq: CNT_W must be at least 1 and below ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] base_q, base_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   order_e            ord_q, ord_d;
   logic              act_q, act_d;

   function automatic logic [CNT_W-1:0] beat_lo(order_e o, logic [CNT_W-1:0] s,
                                                logic [CNT_W-1:0] c);
      logic [CNT_W-1:0] r;
      if (o == ORD_ILV) r = s ^ c;
      else              r = s + c;
      return r;
   endfunction

   always_comb begin
      base_d = base_q;
      cnt_d  = cnt_q;
      ord_d  = ord_q;
      act_d  = act_q;
      if (sleep) begin
         act_d = 1'b0;
      end else if (strobe) begin
         base_d = addr_in;
         cnt_d  = '0;
         ord_d  = order_e'(order_in);
         act_d  = sel_in;
      end else if (act_q && advance) begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         ord_q  <= ORD_LIN;
         act_q  <= 1'b0;
      end else begin
         base_q <= base_d;
         cnt_q  <= cnt_d;
         ord_q  <= ord_d;
         act_q  <= act_d;
      end
   end

   assign cur_addr   = {base_q[ADDR_W-1:CNT_W], beat_lo(ord_q, base_q[CNT_W-1:0], cnt_q)};
   assign nxt_addr   = {base_d[ADDR_W-1:CNT_W], beat_lo(ord_d, base_d[CNT_W-1:0], cnt_d)};
   assign active     = act_q;
   assign nxt_active = act_d;

   // Derived views used by the order checks below.
   logic [CNT_W-1:0] lo_now, lo_inc, rel_now, rel_inc;
   assign lo_now  = cur_addr[CNT_W-1:0];
   assign lo_inc  = lo_now + 1'b1;
   assign rel_now = lo_now ^ base_q[CNT_W-1:0];
   assign rel_inc = rel_now + 1'b1;

   // R1: a strobe edge registers the presented address
   a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !sleep) |=> (cur_addr == $past(addr_in)));

   // R2: within a burst the upper bits stay put
   a_r2_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe) |=> (cur_addr[ADDR_W-1:CNT_W] == $past(cur_addr[ADDR_W-1:CNT_W])));

   // R3: interleaved step advances the XOR distance from the start by one
   a_r3_ilv_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !strobe && act_q && advance && ord_q == ORD_ILV)
      |=> (rel_now == $past(rel_inc)));

   // R4: linear step adds one modulo the group size
   a_r4_lin_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !strobe && act_q && advance && ord_q == ORD_LIN)
      |=> (lo_now == $past(lo_inc)));

   // R5: advance low holds the address
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !advance) |=> $stable(cur_addr));
endmodule

// File: rtl/sbsram_wr_decode.sv
`timescale 1ns/1ps
// Byte-write decode: global write covers every lane, otherwise the byte
// enable qualifies the per-lane selects.
module sbsram_wr_decode #(
   parameter int NB = 4
) (
   input  logic          wr_all,
   input  logic          wr_bytes_en,
   input  logic [NB-1:0] wr_byte_sel,
   output logic [NB-1:0] byte_mask,
   output logic          wr_req
);
   generate
      if (NB < 1) begin : g_bad_nb
         $error("sbsram_wr_decode: NB must be at least 1");
      end
      for (genvar b = 0; b < NB; b++) begin : g_lane
         assign byte_mask[b] = wr_all | (wr_bytes_en & wr_byte_sel[b]);
      end
   endgenerate

   assign wr_req = wr_all | wr_bytes_en;
endmodule

// File: rtl/sbsram_array.sv
`timescale 1ns/1ps
// Behavioural storage: one lane per byte, synchronous write, asynchronous read.
module sbsram_array #(
   parameter int ADDR_W = 8,
   parameter int NB     = 4,
   parameter int BYTE_W = 8
) (
   input  logic                 clk,
   input  logic [NB-1:0]        we,
   input  logic [ADDR_W-1:0]    waddr,
   input  logic [NB*BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]    raddr,
   output logic [NB*BYTE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (DEPTH * NB > 4096) begin : g_too_big
         $error("sbsram_array: storage exceeds the behavioural size limit");
      end
      for (genvar b = 0; b < NB; b++) begin : g_lane
         logic [BYTE_W-1:0] lane_mem [DEPTH];
         always_ff @(posedge clk) begin
            if (we[b]) lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
         end
         assign rdata[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/sbsram_ctrl.sv
`timescale 1ns/1ps
module sbsram_ctrl #(
   parameter int ADDR_W = 8,
   parameter int NB     = 4,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strobe_cpu,
   input  logic                 strobe_ctl,
   input  logic                 chip_sel_a,
   input  logic                 chip_sel_b,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 advance,
   input  logic                 order_ilv,
   input  logic                 wr_all,
   input  logic                 wr_bytes_en,
   input  logic [NB-1:0]        wr_byte_sel,
   input  logic [NB*BYTE_W-1:0] wdata,
   input  logic                 out_en,
   input  logic                 sleep,
   output logic [NB*BYTE_W-1:0] rdata,
   output logic                 rdata_oe
);
   localparam int DW = NB * BYTE_W;

   generate
      if (BYTE_W < 1) begin : g_bad_byte
         $error("sbsram_ctrl: BYTE_W must be at least 1");
      end
   endgenerate

   logic              strobe_any;
   logic              sel_both;
   logic [ADDR_W-1:0] cur_addr, nxt_addr;
   logic              active, nxt_active;
   logic [NB-1:0]     byte_mask, we_mask;
   logic              wr_req, wr_ok;
   logic              last_wr_q;
   logic [DW-1:0]     arr_q;

   assign strobe_any = strobe_cpu | strobe_ctl;
   assign sel_both   = chip_sel_a & chip_sel_b;

   sbsram_burst_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep      (sleep),
      .strobe     (strobe_any),
      .sel_in     (sel_both),
      .order_in   (order_ilv),
      .addr_in    (addr),
      .advance    (advance),
      .cur_addr   (cur_addr),
      .nxt_addr   (nxt_addr),
      .active     (active),
      .nxt_active (nxt_active)
   );

   sbsram_wr_decode #(.NB(NB)) u_dec (
      .wr_all      (wr_all),
      .wr_bytes_en (wr_bytes_en),
      .wr_byte_sel (wr_byte_sel),
      .byte_mask   (byte_mask),
      .wr_req      (wr_req)
   );

   // A write lands on the address this edge registers; a processor strobe
   // edge and any sleep edge never write.
   assign wr_ok   = nxt_active & ~strobe_cpu & ~sleep;
   assign we_mask = wr_ok ? byte_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_wr_q <= 1'b0;
      else        last_wr_q <= wr_ok & wr_req;
   end

   sbsram_array #(.ADDR_W(ADDR_W), .NB(NB), .BYTE_W(BYTE_W)) u_arr (
      .clk   (clk),
      .we    (we_mask),
      .waddr (nxt_addr),
      .wdata (wdata),
      .raddr (cur_addr),
      .rdata (arr_q)
   );

   assign rdata_oe = out_en & active & ~last_wr_q & ~sleep;
   assign rdata    = rdata_oe ? arr_q : '0;

   // R10: output enable low always releases the bus
   always_comb begin
      a_r10_oe_release: assert (out_en || !rdata_oe);
   end

   // R7: global write stores every lane
   a_r7_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_all && nxt_active && !strobe_cpu && !sleep) |-> (&we_mask));

   // R8: no write input active means no lane is written
   a_r8_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_all && !wr_bytes_en) |-> (we_mask == '0));

   // R11: a strobe with a chip select low leaves the bus released
   a_r11_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_any && !sleep && !sel_both) |=> !rdata_oe);

   // R12: sleep writes nothing and the bus stays released after it
   a_r12_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (we_mask == '0));
   a_r12_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !rdata_oe);

   // R13: a processor strobe edge ignores the write inputs
   a_r13_cpu_strobe_read: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_cpu |-> (we_mask == '0));
endmodule

// File: tb/sbsram_ctrl_tb.sv
`timescale 1ns/1ps
module sbsram_ctrl_tb;
   localparam int AW = 8;
   localparam int NB = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strobe_cpu = 0, strobe_ctl = 0, chip_sel_a = 0, chip_sel_b = 0;
   logic [AW-1:0] addr = '0;
   logic          advance = 0, order_ilv = 0, wr_all = 0, wr_bytes_en = 0;
   logic [NB-1:0] wr_byte_sel = '0;
   logic [DW-1:0] wdata = '0;
   logic          out_en = 0, sleep = 0;
   logic [DW-1:0] rdata;
   logic          rdata_oe;

   always #2.5 clk = ~clk;

   sbsram_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
      .chip_sel_a(chip_sel_a), .chip_sel_b(chip_sel_b), .addr(addr),
      .advance(advance), .order_ilv(order_ilv), .wr_all(wr_all),
      .wr_bytes_en(wr_bytes_en), .wr_byte_sel(wr_byte_sel), .wdata(wdata),
      .out_en(out_en), .sleep(sleep), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;

   // Reference model state
   logic [DW-1:0] ref_mem [1 << AW];
   logic          m_act = 0, m_ilv = 0, m_lastwr = 0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;

   function automatic logic [AW-1:0] m_cur();
      logic [1:0] lo;
      lo = m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      return {m_base[AW-1:2], lo};
   endfunction

   function automatic logic [DW-1:0] pattern(logic [AW-1:0] a);
      return (32'(a) * 32'h0103_0507) ^ 32'hA5A5_0000;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic sp, input logic sc, input logic ea, input logic eb,
                       input logic [AW-1:0] a, input logic adv, input logic wa,
                       input logic wbe, input logic [NB-1:0] sel, input logic [DW-1:0] wd,
                       input logic oe, input logic slp, input logic ilv, input string req);
      logic exp_oe;
      logic [DW-1:0] exp_q;
      @(negedge clk);
      strobe_cpu = sp; strobe_ctl = sc; chip_sel_a = ea; chip_sel_b = eb;
      addr = a; advance = adv; wr_all = wa; wr_bytes_en = wbe; wr_byte_sel = sel;
      wdata = wd; out_en = oe; sleep = slp; order_ilv = ilv;
      @(posedge clk);
      #1;
      if (slp) begin
         m_act = 0;
         m_lastwr = 0;
      end else begin
         if (sp || sc) begin
            m_act = ea & eb; m_base = a; m_cnt = '0; m_ilv = ilv;
         end else if (m_act && adv) begin
            m_cnt = m_cnt + 2'd1;
         end
         m_lastwr = m_act && !sp && (wa || wbe);
         if (m_lastwr) begin
            for (int b = 0; b < NB; b++)
               if (wa || sel[b]) ref_mem[m_cur()][b*8 +: 8] = wd[b*8 +: 8];
         end
      end
      exp_oe = oe && m_act && !m_lastwr && !slp;
      exp_q  = exp_oe ? ref_mem[m_cur()] : '0;
      chk(rdata_oe == exp_oe, req, "rdata_oe", 32'(rdata_oe), 32'(exp_oe));
      chk(rdata == exp_q, req, "rdata", rdata, exp_q);
   endtask

   // Read burst helpers
   task automatic rd_start(input logic cpu, input logic [AW-1:0] a, input logic ilv,
                           input string req);
      step(cpu, !cpu, 1, 1, a, 0, 0, 0, '0, '0, 1, 0, ilv, req);
   endtask
   task automatic beat(input logic adv, input string req);
      step(0, 0, 1, 1, '0, adv, 0, 0, '0, '0, 1, 0, 0, req);
   endtask

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5EED_1234);
      repeat (3) @(posedge clk);
      @(negedge clk);
      out_en = 1;
      #1;
      // R11: deselected after reset
      chk(rdata_oe == 1'b0, "R11", "reset rdata_oe", 32'(rdata_oe), 32'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(rdata_oe == 1'b0, "R11", "post-reset rdata_oe", 32'(rdata_oe), 32'd0);

      // R7: preload the whole array with global-write linear bursts
      for (int g = 0; g < (1 << AW); g += 4) begin
         step(0, 1, 1, 1, AW'(g), 0, 1, 0, '0, pattern(AW'(g)), 1, 0, 0, "R7");
         for (int k = 1; k < 4; k++)
            step(0, 0, 1, 1, '0, 1, 1, 0, '0, pattern(AW'(g + k)), 1, 0, 0, "R7");
      end

      // R4, R9, R6: linear read from an unaligned start, then wrap
      rd_start(0, 8'h21, 0, "R9");
      beat(1, "R4"); beat(1, "R4"); beat(1, "R4");
      beat(1, "R6");

      // R3: interleaved read started by the processor strobe
      rd_start(1, 8'h4E, 1, "R3");
      beat(1, "R3"); beat(1, "R3"); beat(1, "R3");
      beat(1, "R6");

      // R5: suspend mid-burst
      rd_start(0, 8'h93, 1, "R1");
      beat(0, "R5"); beat(0, "R5"); beat(1, "R5"); beat(0, "R5"); beat(1, "R5");

      // R8: byte-masked writes, then read back
      step(0, 1, 1, 1, 8'h10, 0, 0, 1, 4'b0101, 32'hDEAD_BEEF, 1, 0, 0, "R8");
      step(0, 0, 1, 1, '0, 1, 0, 1, 4'b1010, 32'h1122_3344, 1, 0, 0, "R8");
      step(0, 0, 1, 1, '0, 1, 0, 1, 4'b0000, 32'hFFFF_FFFF, 1, 0, 0, "R8");
      step(0, 0, 1, 1, '0, 1, 0, 0, 4'b1111, 32'h0BAD_0BAD, 1, 0, 0, "R8");
      rd_start(0, 8'h10, 0, "R8");
      beat(1, "R8"); beat(1, "R8"); beat(1, "R8");

      // R13: processor strobe ignores write inputs, later beats write
      step(1, 1, 1, 1, 8'h30, 0, 1, 0, '0, 32'hCAFE_0001, 1, 0, 0, "R13");
      step(0, 0, 1, 1, '0, 1, 1, 0, '0, 32'hCAFE_0002, 1, 0, 0, "R13");
      rd_start(0, 8'h30, 0, "R13");
      beat(1, "R13");

      // R10: output enable low during a read burst
      rd_start(0, 8'h44, 0, "R10");
      step(0, 0, 1, 1, '0, 1, 0, 0, '0, '0, 0, 0, 0, "R10");
      beat(1, "R10");

      // R11: deselected strobe with write inputs, then read back
      step(0, 1, 1, 0, 8'h50, 0, 1, 0, '0, 32'h5555_AAAA, 1, 0, 0, "R11");
      step(0, 0, 1, 1, '0, 1, 1, 0, '0, 32'h5555_AAAB, 1, 0, 0, "R11");
      rd_start(0, 8'h50, 0, "R11");
      beat(1, "R11");

      // R12: sleep with write inputs, exit stays released, then read back
      rd_start(0, 8'h60, 0, "R12");
      step(0, 0, 1, 1, '0, 1, 1, 0, '0, 32'h7777_7777, 1, 1, 0, "R12");
      step(0, 0, 1, 1, '0, 1, 1, 0, '0, 32'h7777_7778, 1, 1, 0, "R12");
      beat(1, "R12");
      beat(0, "R12");
      rd_start(0, 8'h60, 0, "R12");
      beat(1, "R12"); beat(1, "R12");

      // R1, R2: constrained random bursts
      for (int i = 0; i < 300; i++) begin
         logic cpu, ea, eb, ilv;
         logic [AW-1:0] a;
         cpu = ($urandom % 4) == 0;
         ea  = ($urandom % 8) != 0;
         eb  = ($urandom % 8) != 0;
         ilv = $urandom % 2;
         a   = AW'($urandom);
         step(cpu, !cpu || (($urandom % 2) == 0), ea, eb, a, 0, ($urandom % 4) == 0,
              ($urandom % 4) == 0, NB'($urandom), $urandom, 1, 0, ilv, "R1");
         for (int j = 0; j < 5; j++) begin
            step(0, 0, 1, 1, AW'($urandom), ($urandom % 4) != 0, ($urandom % 5) == 0,
                 ($urandom % 4) == 0, NB'($urandom), $urandom, ($urandom % 8) != 0,
                 ($urandom % 40) == 0, $urandom % 2, "R2");
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule